// File: doc/BRIEF.md
# Shared Buffer RAM Arbiter

This block places one external 16-bit static RAM behind three requesters: an internal MAC engine, a host bus port and a local processor port. Each requester uses a plain handshake. It raises a request together with a word address, a write flag and write data, then holds them until a one-cycle completion pulse comes back. The arbiter chooses one requester at a time. It drives the RAM address, a chip enable for each byte lane and an active-low write strobe, and it holds every requester that is still pending in a wait state until its own access has finished.

Every RAM access takes two clock cycles. In the first cycle the address, write strobe and write data are set up while both chip enables stay inactive. In the second cycle the chip enables of the selected lanes are active, and at the end of that cycle read data is captured. The host and the engine always move whole words. The processor can also select a single byte lane through its upper-byte-enable input and its byte address bit 0. While no access is running, the arbiter drives the RAM data bus to all zeros so that it never floats.

Top module: `buf_ram_arb`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ram_ce_n` = 2'b11, `ram_we_n` = 1, `ram_dq_oe` = 1, `ram_dq_o` = 0, and every `*_done` output is 0.
- R2: A request sampled while the arbiter is free gives a setup cycle with `ram_ce_n` = 2'b11. It is followed by exactly one cycle with chip enables active, and the owner's done pulse comes in the cycle after that. Once the first access ends, the next pending access starts with no idle cycle, so accesses repeat every 2 cycles.
- R3: The full 17-bit word address of the granted requester appears on `ram_addr` for both cycles of its access.
- R4: Engine and host accesses always activate both lanes (`ram_ce_n` = 2'b00).
- R5: The processor lane choice is as follows. With `cpu_ube`=1, `cpu_a0`=0 the access is a word (2'b00). With `cpu_ube`=0, `cpu_a0`=0 only the low lane is used (`ram_ce_n[0]` active, 2'b10). With `cpu_ube`=1, `cpu_a0`=1 only the high lane is used (2'b01). With `cpu_ube`=0, `cpu_a0`=1 no lane is used (2'b11), and that access still completes and leaves the RAM unchanged.
- R6: `ram_we_n` is low for writes and high for reads from the setup cycle on. It and `ram_addr` do not change while a chip enable is active.
- R7: When no access is running, the data bus is driven (`ram_dq_oe`=1) at all zeros. During a write the bus carries the write data. During a read it is released (`ram_dq_oe`=0).
- R8: When several requests arrive together, the engine is served first, then the host, then the processor.
- R9: Read data that the RAM returns during the active cycle appears on `rd_data` while the owner's done pulse is high. At most one done output is high in any cycle.
- R10: A requester's `*_wait` output is high in every cycle in which its request is high and its done pulse is not.
- R11: An access that has started always runs to completion. A higher-priority request that arrives during the setup cycle is served only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_req | input | 1 | Engine request, held until done |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | 17 | Engine word address |
| eng_wdata | input | 16 | Engine write data |
| eng_wait | output | 1 | Engine stalled |
| eng_done | output | 1 | Engine access complete |
| host_req | input | 1 | Host request, held until done |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 17 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_wait | output | 1 | Host stalled |
| host_done | output | 1 | Host access complete |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_ube | input | 1 | Processor upper byte enable, active high |
| cpu_a0 | input | 1 | Processor byte address bit 0 |
| cpu_addr | input | 17 | Processor word address |
| cpu_wdata | input | 16 | Processor write data (odd byte in bits 15:8) |
| cpu_wait | output | 1 | Processor stalled |
| cpu_done | output | 1 | Processor access complete |
| rd_data | output | 16 | Read data, valid with a done pulse |
| ram_addr | output | 17 | RAM word address |
| ram_ce_n | output | 2 | Lane chip enables, active low; bit 0 low byte, bit 1 high byte |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_o | output | 16 | RAM data bus output value |
| ram_dq_oe | output | 1 | RAM data bus output enable |
| ram_dq_i | input | 16 | RAM data bus input value |

## Verification
The hardest condition to create is the end of an access while other requests are still pending. At that edge the arbiter has to skip the owner that is just finishing and hand over to the next requester with no idle cycle. The bench produces it by raising all three requests in the same cycle and letting each requester drop its request only when it sees its own done pulse. The expected done pulses fall in cycles 3, 5 and 7. A second directed case raises the engine request during the processor's setup cycle, which shows that the access already under way is not cut short. A small RAM model in the bench stores only the enabled lanes. It is compared with a shadow copy that the bench updates from the lane rules, so an access that enables no lane has to leave memory unchanged.

// File: rtl/bra_pkg.sv
package bra_pkg;

  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int NREQ   = 3;

  // requester slots, lower index wins
  localparam int IX_ENG  = 0;
  localparam int IX_HOST = 1;
  localparam int IX_CPU  = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;

  // lane mask (bit0 low byte, bit1 high byte) for a processor access
  function automatic logic [LANES-1:0] cpu_lanes(input logic ube, input logic a0);
    logic [LANES-1:0] m;
    case ({ube, a0})
      2'b10:   m = 2'b11;
      2'b00:   m = 2'b01;
      2'b11:   m = 2'b10;
      default: m = 2'b00;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bra_prio.sv
module bra_prio #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N-1:0] elig;
  logic [N:0]   taken;

  assign elig     = req & ~mask;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]   = elig[i] & ~taken[i];
    assign taken[i+1] = taken[i] | elig[i];
  end

  assign any = taken[N];

endmodule

// File: rtl/bra_mux.sv
module bra_mux #(
  parameter int N  = 3,
  parameter int AW = 17,
  parameter int DW = 16,
  parameter int LN = 2
) (
  input  logic [N*AW-1:0] addr_flat,
  input  logic [N*DW-1:0] wdata_flat,
  input  logic [N*LN-1:0] lanes_flat,
  input  logic [N-1:0]    we,
  input  logic [N-1:0]    grant,
  output logic [AW-1:0]   sel_addr,
  output logic [DW-1:0]   sel_wdata,
  output logic [LN-1:0]   sel_lanes,
  output logic            sel_we
);

  logic [AW-1:0] a_acc [N+1];
  logic [DW-1:0] d_acc [N+1];
  logic [LN-1:0] l_acc [N+1];
  logic          w_acc [N+1];

  assign a_acc[0] = '0;
  assign d_acc[0] = '0;
  assign l_acc[0] = '0;
  assign w_acc[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_andor
    assign a_acc[i+1] = a_acc[i] | (addr_flat[i*AW +: AW]  & {AW{grant[i]}});
    assign d_acc[i+1] = d_acc[i] | (wdata_flat[i*DW +: DW] & {DW{grant[i]}});
    assign l_acc[i+1] = l_acc[i] | (lanes_flat[i*LN +: LN] & {LN{grant[i]}});
    assign w_acc[i+1] = w_acc[i] | (we[i] & grant[i]);
  end

  assign sel_addr  = a_acc[N];
  assign sel_wdata = d_acc[N];
  assign sel_lanes = l_acc[N];
  assign sel_we    = w_acc[N];

endmodule

// File: rtl/bra_seq.sv
module bra_seq
  import bra_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 17,
  parameter int DW = 16,
  parameter int LN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [N-1:0]  grant,
  input  logic [AW-1:0] sel_addr,
  input  logic [DW-1:0] sel_wdata,
  input  logic [LN-1:0] sel_lanes,
  input  logic          sel_we,
  input  logic [DW-1:0] ram_dq_i,
  output logic          ending,
  output logic [N-1:0]  owner,
  output logic [N-1:0]  done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic [LN-1:0] ram_ce_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe
);

  phase_t        phase;
  logic [LN-1:0] lanes_q;
  logic          free;

  assign ending = (phase == PH_STROBE);
  assign free   = (phase == PH_IDLE) || ending;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      owner     <= '0;
      done      <= '0;
      rd_data   <= '0;
      lanes_q   <= '0;
      ram_addr  <= '0;
      ram_ce_n  <= '1;
      ram_we_n  <= 1'b1;
      ram_dq_o  <= '0;
      ram_dq_oe <= 1'b1;
    end else begin
      done <= '0;

      // completion of the active strobe cycle
      if (ending) begin
        ram_ce_n <= '1;
        done     <= owner;
        if (ram_we_n) rd_data <= ram_dq_i;
      end

      if (phase == PH_SETUP) begin
        ram_ce_n <= ~lanes_q;
        phase    <= PH_STROBE;
      end else if (free && start) begin
        // setup cycle of a new access: strobes inactive
        phase     <= PH_SETUP;
        owner     <= grant;
        lanes_q   <= sel_lanes;
        ram_addr  <= sel_addr;
        ram_we_n  <= ~sel_we;
        ram_dq_o  <= sel_we ? sel_wdata : '0;
        ram_dq_oe <= sel_we;
      end else if (ending) begin
        phase     <= PH_IDLE;
        owner     <= '0;
        ram_we_n  <= 1'b1;
        ram_dq_o  <= '0;
        ram_dq_oe <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/buf_ram_arb.sv
module buf_ram_arb
  import bra_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_wait,
  output logic              eng_done,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_wait,
  output logic              host_done,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_ube,
  input  logic              cpu_a0,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_wait,
  output logic              cpu_done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [LANES-1:0]  ram_ce_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i
);

  logic [NREQ-1:0]        req, we, grant, owner, done, mask;
  logic [NREQ*ADDR_W-1:0] addr_flat;
  logic [NREQ*DATA_W-1:0] wdata_flat;
  logic [NREQ*LANES-1:0]  lanes_flat;
  logic                   any, ending;
  logic [ADDR_W-1:0]      sel_addr;
  logic [DATA_W-1:0]      sel_wdata;
  logic [LANES-1:0]       sel_lanes;
  logic                   sel_we;

  assign req[IX_ENG]  = eng_req;
  assign req[IX_HOST] = host_req;
  assign req[IX_CPU]  = cpu_req;
  assign we[IX_ENG]   = eng_we;
  assign we[IX_HOST]  = host_we;
  assign we[IX_CPU]   = cpu_we;

  assign addr_flat  = {cpu_addr, host_addr, eng_addr};
  assign wdata_flat = {cpu_wdata, host_wdata, eng_wdata};
  // engine and host are word-only; processor lanes from ube/a0
  assign lanes_flat = {cpu_lanes(cpu_ube, cpu_a0), {LANES{1'b1}}, {LANES{1'b1}}};

  // the owner finishing this cycle is not eligible again at the same edge
  assign mask = ending ? owner : '0;

  bra_prio #(.N(NREQ)) i_prio (
    .req   (req),
    .mask  (mask),
    .grant (grant),
    .any   (any)
  );

  bra_mux #(.N(NREQ), .AW(ADDR_W), .DW(DATA_W), .LN(LANES)) i_mux (
    .addr_flat  (addr_flat),
    .wdata_flat (wdata_flat),
    .lanes_flat (lanes_flat),
    .we         (we),
    .grant      (grant),
    .sel_addr   (sel_addr),
    .sel_wdata  (sel_wdata),
    .sel_lanes  (sel_lanes),
    .sel_we     (sel_we)
  );

  bra_seq #(.N(NREQ), .AW(ADDR_W), .DW(DATA_W), .LN(LANES)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (any),
    .grant     (grant),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata),
    .sel_lanes (sel_lanes),
    .sel_we    (sel_we),
    .ram_dq_i  (ram_dq_i),
    .ending    (ending),
    .owner     (owner),
    .done      (done),
    .rd_data   (rd_data),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_we_n  (ram_we_n),
    .ram_dq_o  (ram_dq_o),
    .ram_dq_oe (ram_dq_oe)
  );

  assign eng_done  = done[IX_ENG];
  assign host_done = done[IX_HOST];
  assign cpu_done  = done[IX_CPU];

  // R10: stalled while pending and not completing
  assign eng_wait  = eng_req  & ~eng_done;
  assign host_wait = host_req & ~host_done;
  assign cpu_wait  = cpu_req  & ~cpu_done;

endmodule

// File: rtl/bra_chk.sv
module bra_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] ram_addr,
  input logic [1:0]    ram_ce_n,
  input logic          ram_we_n,
  input logic [15:0]   ram_dq_o,
  input logic          ram_dq_oe,
  input logic          eng_done,
  input logic          host_done,
  input logic          cpu_done
);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (ram_ce_n != 2'b11) |=> (ram_ce_n == 2'b11));

  a_r6_strobe_stable: assert property (@(posedge clk) disable iff (rst)
    (ram_ce_n != 2'b11) |-> ($stable(ram_we_n) && $stable(ram_addr)));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (ram_dq_oe && ram_we_n) |-> (ram_dq_o == '0));

  a_r7_write_drives: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> ram_dq_oe);

  a_r9_one_done: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eng_done, host_done, cpu_done}));

  a_r4_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (eng_done || host_done) |-> ($past(ram_ce_n) == 2'b00));

endmodule

bind buf_ram_arb bra_chk #(.AW(ADDR_W)) i_bra_chk (
  .clk       (clk),
  .rst       (rst),
  .ram_addr  (ram_addr),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .ram_dq_o  (ram_dq_o),
  .ram_dq_oe (ram_dq_oe),
  .eng_done  (eng_done),
  .host_done (host_done),
  .cpu_done  (cpu_done)
);

// File: tb/test_buf_ram_arb.sv
`timescale 1ns/1ps
module test_buf_ram_arb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eng_req = 0, eng_we = 0, host_req = 0, host_we = 0;
  logic        cpu_req = 0, cpu_we = 0, cpu_ube = 0, cpu_a0 = 0;
  logic [16:0] eng_addr = 0, host_addr = 0, cpu_addr = 0;
  logic [15:0] eng_wdata = 0, host_wdata = 0, cpu_wdata = 0;
  logic        eng_wait, eng_done, host_wait, host_done, cpu_wait, cpu_done;
  logic [15:0] rd_data, ram_dq_o, ram_dq_i;
  logic [16:0] ram_addr;
  logic [1:0]  ram_ce_n;
  logic        ram_we_n, ram_dq_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  buf_ram_arb i_buf_ram_arb (.*);

  // small RAM model, aliased on the low address byte
  logic [15:0] sram [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin sram[i] = 16'h0; shadow[i] = 16'h0; end

  always @(posedge clk) if (!ram_we_n) begin
    if (!ram_ce_n[0]) sram[ram_addr[7:0]][7:0]  <= ram_dq_o[7:0];
    if (!ram_ce_n[1]) sram[ram_addr[7:0]][15:8] <= ram_dq_o[15:8];
  end
  assign ram_dq_i = ram_we_n ?
    { ram_ce_n[1] ? 8'h00 : sram[ram_addr[7:0]][15:8],
      ram_ce_n[0] ? 8'h00 : sram[ram_addr[7:0]][7:0] } : 16'h0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int who, input logic r, input logic w, input logic [16:0] a,
                       input logic [15:0] d, input logic u, input logic b0);
    case (who)
      0: begin eng_req = r; eng_we = w; eng_addr = a; eng_wdata = d; end
      1: begin host_req = r; host_we = w; host_addr = a; host_wdata = d; end
      default: begin cpu_req = r; cpu_we = w; cpu_addr = a; cpu_wdata = d; cpu_ube = u; cpu_a0 = b0; end
    endcase
  endtask

  function automatic logic [2:0] dones();
    return {cpu_done, host_done, eng_done};
  endfunction

  // who[39:38] we[37] ube[36] a0[35] lanes-active[34:33] addr[32:16] data[15:0]
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 2'b11, 17'h10012, 16'hA5C3},  // R4 engine word write
    {2'd1, 1'b0, 1'b0, 1'b0, 2'b11, 17'h10012, 16'h0000},  // R9 host read
    {2'd2, 1'b1, 1'b0, 1'b0, 2'b01, 17'h00034, 16'h1177},  // R5 low byte write
    {2'd2, 1'b1, 1'b1, 1'b1, 2'b10, 17'h00034, 16'h8899},  // R5 high byte write
    {2'd2, 1'b0, 1'b1, 1'b0, 2'b11, 17'h00034, 16'h0000},  // R5 word read
    {2'd2, 1'b0, 1'b0, 1'b0, 2'b01, 17'h00034, 16'h0000},  // R5 low byte read
    {2'd2, 1'b0, 1'b1, 1'b1, 2'b10, 17'h00034, 16'h0000},  // R5 high byte read
    {2'd2, 1'b1, 1'b0, 1'b1, 2'b00, 17'h00034, 16'hFFFF},  // R5 no-lane write
    {2'd1, 1'b0, 1'b0, 1'b0, 2'b11, 17'h00034, 16'h0000},  // R5 memory unchanged
    {2'd0, 1'b1, 1'b0, 1'b0, 2'b11, 17'h1FFFF, 16'hBEEF},  // R3 top address
    {2'd0, 1'b0, 1'b0, 1'b0, 2'b11, 17'h000FF, 16'h0000}   // R3 alias read back
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ram_ce_n == 2'b11 && ram_we_n && ram_dq_oe && ram_dq_o == 0, "R1 pins in reset",
        {ram_ce_n, ram_we_n, ram_dq_oe, ram_dq_o}, {2'b11, 1'b1, 1'b1, 16'h0});
    rst = 1'b0;
    @(negedge clk);
    chk(ram_ce_n == 2'b11 && ram_dq_oe && ram_dq_o == 0 && dones() == 0, "R1 after reset",
        {dones(), ram_ce_n, ram_dq_oe, ram_dq_o}, {3'b0, 2'b11, 1'b1, 16'h0});

    for (int v = 0; v < NV; v++) begin
      automatic int          who = int'(VEC[v][39:38]);
      automatic logic        w   = VEC[v][37];
      automatic logic [1:0]  ln  = VEC[v][34:33];
      automatic logic [16:0] a   = VEC[v][32:16];
      automatic logic [15:0] d   = VEC[v][15:0];
      automatic logic [15:0] exp_rd;
      drive(who, 1'b1, w, a, d, VEC[v][36], VEC[v][35]);
      @(negedge clk);  // setup cycle
      chk(ram_ce_n == 2'b11 && ram_we_n == !w && ram_addr == a, "R2 R6 setup cycle",
          {ram_ce_n, ram_we_n, ram_addr}, {2'b11, !w, a});
      chk(ram_dq_oe == w && (!w || ram_dq_o == d), "R7 bus during access",
          {ram_dq_oe, ram_dq_o}, {w, d});
      chk(dones() == 0 && (who != 2 || cpu_wait) && (who != 0 || eng_wait), "R10 wait while pending",
          {dones(), cpu_wait, eng_wait}, 0);
      @(negedge clk);  // strobe cycle
      chk(ram_ce_n == ~ln && ram_we_n == !w && ram_addr == a, "R3 R4 R5 strobe lanes",
          {ram_ce_n, ram_we_n, ram_addr}, {~ln, !w, a});
      @(negedge clk);  // done cycle
      exp_rd = {ln[1] ? shadow[a[7:0]][15:8] : 8'h00, ln[0] ? shadow[a[7:0]][7:0] : 8'h00};
      chk(dones() == (3'b001 << who), "R2 R9 done pulse", dones(), 3'b001 << who);
      if (!w) chk(rd_data == exp_rd, "R9 read data", rd_data, exp_rd);
      if (w) begin
        if (ln[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (ln[1]) shadow[a[7:0]][15:8] = d[15:8];
      end
      chk(ram_ce_n == 2'b11 && ram_dq_oe && ram_dq_o == 0, "R7 idle bus zero",
          {ram_ce_n, ram_dq_oe, ram_dq_o}, {2'b11, 1'b1, 16'h0});
      drive(who, 1'b0, 1'b0, 17'h0, 16'h0, 1'b0, 1'b0);
      @(negedge clk);
    end

    // R8 priority and R2 back-to-back: all three at once
    begin
      automatic int when [3] = '{0, 0, 0};
      drive(0, 1'b1, 1'b1, 17'h00040, 16'h0E0E, 1'b0, 1'b0);
      drive(1, 1'b1, 1'b1, 17'h00041, 16'h0B0B, 1'b0, 1'b0);
      drive(2, 1'b1, 1'b1, 17'h00042, 16'h0C0C, 1'b1, 1'b0);
      for (int c = 1; c <= 8; c++) begin
        @(negedge clk);
        if (c == 1) chk(host_wait && cpu_wait, "R10 losers wait", {host_wait, cpu_wait}, 2'b11);
        for (int k = 0; k < 3; k++) if (dones()[k]) begin
          when[k] = c;
          drive(k, 1'b0, 1'b0, 17'h0, 16'h0, 1'b0, 1'b0);
        end
      end
      chk(when[0] == 3, "R8 engine first", when[0], 3);
      chk(when[1] == 5, "R8 host second", when[1], 5);
      chk(when[2] == 7, "R8 R2 processor third", when[2], 7);
    end

    // R11 no abort: processor starts, engine arrives in its setup cycle
    begin
      drive(2, 1'b1, 1'b0, 17'h00041, 16'h0, 1'b0, 1'b0);   // low byte read
      @(negedge clk);
      drive(0, 1'b1, 1'b0, 17'h00040, 16'h0, 1'b0, 1'b0);
      @(negedge clk);
      chk(ram_ce_n == 2'b10 && ram_addr == 17'h00041, "R11 processor strobe kept",
          {ram_ce_n, ram_addr}, {2'b10, 17'h00041});
      @(negedge clk);
      chk(dones() == 3'b100 && rd_data == 16'h000B, "R11 processor finishes first",
          {dones(), rd_data}, {3'b100, 16'h000B});
      drive(2, 1'b0, 1'b0, 17'h0, 16'h0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk(dones() == 3'b001 && rd_data == 16'h0E0E, "R11 engine follows",
          {dones(), rd_data}, {3'b001, 16'h0E0E});
      drive(0, 1'b0, 1'b0, 17'h0, 16'h0, 1'b0, 1'b0);
      @(negedge clk);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule